// File: doc/BRIEF.md
# LCD Frame Buffer Address Generator

This block produces the word fetch addresses for an LCD refresh engine that scans a linear frame buffer. A 4-bit region register supplies the top nibble of every 32-bit address. Inside that region the buffer always begins at offset zero. While the controller is enabled, each accepted fetch moves the address on by one 32-bit word. After the last word of the programmed buffer size, the address returns to the start of the frame.

Alongside the addresses, the block flags the last word of each screen line and the last word of the frame. It also splits each fetched 32-bit word into eight 4-bit pixels. The lowest nibble comes out first. Line length is given in units of 16 pixels, which is two words at 4 bits per pixel. Buffer size is given in words, up to 32768 words (128 KB). Both settings must be held stable while the controller is enabled.

Top module: `lcd_fb_addr_gen`

## Requirements
- R1: After reset the region nibble is 0xC, so `fetch_addr` reads 0xC000_0000.
- R2: A pulse on `base_wr` while `enable` is low loads `base_wdata` into the region nibble, and `fetch_addr[31:28]` shows it from the next cycle.
- R3: A pulse on `base_wr` while `enable` is high is ignored, and `fetch_addr[31:28]` keeps its value.
- R4: `fetch_addr` equals the region nibble in bits 31:28 and the word index times 4 in bits 27:0. Bits 1:0 are always zero and the first fetch after enable is at offset 0.
- R5: The word index goes up by one on each cycle with `enable` and `fetch_ack` both high. It holds when `fetch_ack` is low.
- R6: `line_end` is high in the cycle where the accepted fetch is the last word of a line. A line is 2 × `line_units` words, for 32 to 1024 pixels with `line_units` from 2 to 64. The line position then restarts at zero.
- R7: `frame_end` is high in the cycle where the accepted fetch has word index `frame_words`−1. The next address has offset 0 with no idle cycle, and the line position restarts too.
- R8: While `enable` is low, `fetch_req` is low and the word index and line position return to zero.
- R9: A word accepted on `word_valid`/`word_ready` comes out on `pix_data` as eight nibbles, starting with bits 3:0 and moving up one nibble per cycle. The first nibble appears in the cycle after acceptance.
- R10: `pix_valid` is high while nibbles remain. `word_ready` is high when `enable` is high and at most one nibble remains, so consecutive words stream with no gap.
- R11: While `enable` is low, `word_ready` is low and any remaining nibbles are discarded, so `pix_valid` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enabled |
| base_wr | input | 1 | Region nibble write strobe |
| base_wdata | input | 4 | Region nibble write value |
| line_units | input | 7 | Line length in 16-pixel units (2..64) |
| frame_words | input | 16 | Buffer size in 32-bit words (1..32768) |
| fetch_ack | input | 1 | Current fetch accepted by memory side |
| fetch_req | output | 1 | Fetch requested |
| fetch_addr | output | 32 | Byte address of current word fetch |
| line_end | output | 1 | Accepted fetch is the last word of a line |
| frame_end | output | 1 | Accepted fetch is the last word of the frame |
| word_valid | input | 1 | Fetched word offered for unpacking |
| word_data | input | 32 | Fetched word |
| word_ready | output | 1 | Unpacker can take a word this cycle |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | 4 | Current 4-bit pixel |

## Verification
`fetch_req`, `line_end`, `frame_end` and `word_ready` depend on the current inputs and the registered state in the same cycle. A region write and an address step show up on `fetch_addr` one edge later. The first nibble of an accepted word reaches `pix_data` one edge after the handshake. The bench drives its inputs just after each falling edge and compares every output 1 ns later against a behavioural model. The model has already been stepped for the rising edge in between, so each result is checked in exactly the cycle it is due.

// File: rtl/lcd_fb_pkg.sv
// Shared definitions for the LCD frame buffer address generator.
// Assumes 32-bit words and a 16-pixel granularity for line lengths.
package lcd_fb_pkg;

    // Per-fetch position markers produced by the address counter.
    typedef struct packed {
        logic eol;
        logic eof;
    } fb_mark_t;

    // Number of buffer words covering one 16-pixel line unit.
    function automatic int unsigned words_per_unit(input int unsigned pix_w,
                                                   input int unsigned word_w);
        return (16 * pix_w) / word_w;
    endfunction

endpackage

// File: rtl/lcd_fb_base_reg.sv
// Region nibble register: holds the top address bits of the frame buffer.
// Assumes software writes it only while the controller is disabled; writes
// arriving while enabled are dropped so an in-flight fetch keeps its region.
module lcd_fb_base_reg #(
    parameter int unsigned         BASE_W  = 4,
    parameter logic [BASE_W-1:0]   RST_VAL = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr,
    input  logic [BASE_W-1:0] wdata,
    output logic [BASE_W-1:0] base
);

    // Load the nibble only when the controller is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= RST_VAL;
        end else if (wr && !enable) begin
            base <= wdata;
        end
    end

endmodule

// File: rtl/lcd_fb_addr_ctr.sv
// Word index and line position counters for the frame scan.
// Assumes line_units and frame_words stay stable while enabled and that
// frame_words is at least 1. Markers are combinational with the accepted fetch.
module lcd_fb_addr_ctr
    import lcd_fb_pkg::*;
#(
    parameter int unsigned IDX_W = 15,
    parameter int unsigned LU_W  = 7,
    parameter int unsigned WPU   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fetch_ack,
    input  logic [LU_W-1:0]  line_units,
    input  logic [IDX_W:0]   frame_words,
    output logic [IDX_W-1:0] widx,
    output fb_mark_t         mark
);

    localparam int unsigned LC_W = LU_W + $clog2(WPU) + 1;

    logic [LC_W-1:0] lcnt;
    logic [LC_W-1:0] lend;
    logic [IDX_W:0]  fend;
    logic            at_eol;
    logic            at_eof;
    logic            step;

    // Last word position of a line and of the frame.
    always_comb begin
        lend   = LC_W'(line_units) * LC_W'(WPU) - LC_W'(1);
        fend   = frame_words - (IDX_W+1)'(1);
        at_eol = (lcnt == lend);
        at_eof = ({1'b0, widx} == fend);
        step   = enable && fetch_ack;
        mark.eol = step && at_eol;
        mark.eof = step && at_eof;
    end

    // Advance position on each accepted fetch, wrap at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            widx <= '0;
            lcnt <= '0;
        end else if (fetch_ack) begin
            if (at_eof) begin
                widx <= '0;
                lcnt <= '0;
            end else begin
                widx <= widx + IDX_W'(1);
                lcnt <= at_eol ? '0 : lcnt + LC_W'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_fb_pix_unpack.sv
// Splits fetched words into pixels, least significant pixel first.
// Assumes the pixel sink takes one pixel every cycle while pix_valid is high.
// A new word is taken when at most one pixel remains, so words stream gaplessly.
module lcd_fb_pix_unpack #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PIX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data
);

    localparam int unsigned NPIX  = WORD_W / PIX_W;
    localparam int unsigned CNT_W = $clog2(NPIX + 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              load;

    // Handshake and output view of the shift register.
    always_comb begin
        word_ready = enable && (left <= CNT_W'(1));
        load       = word_ready && word_valid;
        pix_valid  = (left != '0);
        pix_data   = shreg[PIX_W-1:0];
    end

    // Load a word or shift one pixel out per cycle; flush when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= word_data;
            left  <= CNT_W'(NPIX);
        end else if (left != '0) begin
            shreg <= shreg >> PIX_W;
            left  <= left - CNT_W'(1);
        end
    end

endmodule

// File: rtl/lcd_fb_addr_gen.sv
// Top level: forms fetch addresses from the region nibble and word index,
// flags line and frame ends, and unpacks fetched words into pixels.
// Assumes configuration inputs are stable while enable is high.
module lcd_fb_addr_gen
    import lcd_fb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BASE_W = 4,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PIX_W  = 4,
    parameter int unsigned IDX_W  = 15,
    parameter int unsigned LU_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic [LU_W-1:0]   line_units,
    input  logic [IDX_W:0]    frame_words,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              line_end,
    output logic              frame_end,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data
);

    localparam int unsigned OFF_W   = ADDR_W - BASE_W;
    localparam int unsigned BYTE_SH = $clog2(WORD_W / 8);
    localparam int unsigned PAD_W   = OFF_W - IDX_W - BYTE_SH;
    localparam int unsigned WPU     = words_per_unit(PIX_W, WORD_W);

    logic [BASE_W-1:0] base;
    logic [IDX_W-1:0]  widx;
    logic [OFF_W-1:0]  offset;
    fb_mark_t          mark;

    lcd_fb_base_reg #(
        .BASE_W  (BASE_W),
        .RST_VAL (BASE_W'(4'hC))
    ) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .wr     (base_wr),
        .wdata  (base_wdata),
        .base   (base)
    );

    lcd_fb_addr_ctr #(
        .IDX_W (IDX_W),
        .LU_W  (LU_W),
        .WPU   (WPU)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .fetch_ack   (fetch_ack),
        .line_units  (line_units),
        .frame_words (frame_words),
        .widx        (widx),
        .mark        (mark)
    );

    lcd_fb_pix_unpack #(
        .WORD_W (WORD_W),
        .PIX_W  (PIX_W)
    ) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data)
    );

    // Byte offset of the current word, zero padded when the index is narrow.
    generate
        if (PAD_W > 0) begin : g_pad
            assign offset = {{PAD_W{1'b0}}, widx, {BYTE_SH{1'b0}}};
        end else begin : g_nopad
            assign offset = {widx, {BYTE_SH{1'b0}}};
        end
    endgenerate

    // Drive fetch side outputs.
    always_comb begin
        fetch_req  = enable;
        fetch_addr = {base, offset};
        line_end   = mark.eol;
        frame_end  = mark.eof;
    end

endmodule

// File: rtl/lcd_fb_addr_gen_chk.sv
// Temporal checks on the address generator ports, bound to the top module.
module lcd_fb_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        base_wr,
    input logic [3:0]  base_wdata,
    input logic        fetch_ack,
    input logic [31:0] fetch_addr,
    input logic        frame_end,
    input logic        pix_valid,
    input logic        word_ready
);

    // R2: write while stopped shows on the address next cycle
    p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !enable) |=> (fetch_addr[31:28] == $past(base_wdata)));

    // R3: write while running leaves the region nibble untouched
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && enable) |=> $stable(fetch_addr[31:28]));

    // R5: no acceptance, no address movement
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fetch_ack) |=> $stable(fetch_addr));

    // R7: frame end returns the offset to zero
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (fetch_addr[27:0] == 28'h0));

    // R8: a stopped controller restarts at offset zero
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fetch_addr[27:0] == 28'h0));

    // R10: pixels still pending keep pix_valid high
    p_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pix_valid && !word_ready) |=> pix_valid);

    // R11: disabling flushes the unpacker
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pix_valid);

endmodule

bind lcd_fb_addr_gen lcd_fb_addr_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .base_wr    (base_wr),
    .base_wdata (base_wdata),
    .fetch_ack  (fetch_ack),
    .fetch_addr (fetch_addr),
    .frame_end  (frame_end),
    .pix_valid  (pix_valid),
    .word_ready (word_ready)
);

// File: tb/lcd_fb_addr_gen_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module lcd_fb_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        base_wr;
    logic [3:0]  base_wdata;
    logic [6:0]  line_units;
    logic [15:0] frame_words;
    logic        fetch_ack;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        line_end;
    logic        frame_end;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_ready;
    logic        pix_valid;
    logic [3:0]  pix_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state
    int m_base;
    int m_widx;
    int m_lpos;
    int m_pix[$];

    always #2 clk = ~clk;

    lcd_fb_addr_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .base_wr     (base_wr),
        .base_wdata  (base_wdata),
        .line_units  (line_units),
        .frame_words (frame_words),
        .fetch_ack   (fetch_ack),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .line_end    (line_end),
        .frame_end   (frame_end),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_ready  (word_ready),
        .pix_valid   (pix_valid),
        .pix_data    (pix_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Compare all outputs against the model, then step the model over the edge.
    task automatic cyc();
        int  wpl;
        bit  eol;
        bit  eof;
        bit  rdy;
        longint ea;
        #1;
        wpl = 2 * int'(line_units);
        eol = enable && fetch_ack && (m_lpos == wpl - 1);
        eof = enable && fetch_ack && (m_widx == int'(frame_words) - 1);
        rdy = enable && (m_pix.size() <= 1);
        ea  = (longint'(m_base) << 28) | (longint'(m_widx) << 2);
        if (rst_n) begin
            chk(fetch_req == enable, "R8 fetch_req", fetch_req, enable);
            chk(fetch_addr == ea[31:0], "R2 R3 R4 R5 fetch_addr", fetch_addr, ea);
            chk(line_end == eol, "R6 line_end", line_end, eol);
            chk(frame_end == eof, "R7 frame_end", frame_end, eof);
            chk(word_ready == rdy, "R10 word_ready", word_ready, rdy);
            chk(pix_valid == (m_pix.size() > 0), "R10 R11 pix_valid", pix_valid, m_pix.size() > 0);
            if (m_pix.size() > 0)
                chk(pix_data == m_pix[0][3:0], "R9 pix_data", pix_data, m_pix[0]);
        end
        if (!rst_n) begin
            m_base = 12; m_widx = 0; m_lpos = 0; m_pix.delete();
        end else begin
            if (base_wr && !enable) m_base = int'(base_wdata);
            if (!enable) begin
                m_widx = 0; m_lpos = 0; m_pix.delete();
            end else begin
                if (fetch_ack) begin
                    if (eof) begin m_widx = 0; m_lpos = 0; end
                    else begin
                        m_widx++;
                        m_lpos = eol ? 0 : m_lpos + 1;
                    end
                end
                if (m_pix.size() > 0) void'(m_pix.pop_front());
                if (rdy && word_valid)
                    for (int k = 0; k < 8; k++) m_pix.push_back(int'(word_data[4*k +: 4]));
            end
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input int ack_pct, input int wv_pct);
        for (int i = 0; i < n; i++) begin
            fetch_ack  = ($urandom % 100) < ack_pct;
            word_valid = ($urandom % 100) < wv_pct;
            word_data  = $urandom;
            base_wr    = 1'b0;
            cyc();
        end
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        rst_n = 1'b0; enable = 1'b0; base_wr = 1'b0; base_wdata = 4'h0;
        line_units = 7'd2; frame_words = 16'd10; fetch_ack = 1'b0;
        word_valid = 1'b0; word_data = '0;
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset region nibble
        chk(fetch_addr == 32'hC000_0000, "R1 reset address", fetch_addr, 32'hC000_0000);

        // R2: write while stopped
        base_wr = 1'b1; base_wdata = 4'h6; cyc();
        base_wr = 1'b0; cyc();
        chk(fetch_addr[31:28] == 4'h6, "R2 region load", fetch_addr[31:28], 6);

        // R4 R5 R6 R7: short lines, frame not a multiple of a line
        enable = 1'b1; fetch_ack = 1'b1; cyc();
        run(60, 100, 100);
        // R3: write while running is dropped
        base_wr = 1'b1; base_wdata = 4'h9; cyc();
        base_wr = 1'b0; cyc();
        chk(fetch_addr[31:28] == 4'h6, "R3 region kept", fetch_addr[31:28], 6);
        run(400, 60, 30);

        // R11: stop flushes pixels and restarts address
        enable = 1'b0; fetch_ack = 1'b0; word_valid = 1'b0; cyc();
        chk(!pix_valid, "R11 flush", pix_valid, 0);
        chk(fetch_addr[27:0] == 28'h0, "R8 restart", fetch_addr[27:0], 0);

        // R6 R7: new geometry, frame equal to two lines
        line_units = 7'd3; frame_words = 16'd12;
        base_wr = 1'b1; base_wdata = 4'h0; cyc();
        base_wr = 1'b0;
        enable = 1'b1; cyc();
        run(300, 80, 50);
        enable = 1'b0; cyc();
        run(5, 50, 50);

        // Widest line, one-word frame boundary
        line_units = 7'd64; frame_words = 16'd1;
        enable = 1'b1; cyc();
        run(50, 100, 100);
        enable = 1'b0; cyc();
        line_units = 7'd64; frame_words = 16'd300;
        enable = 1'b1; cyc();
        run(1200, 90, 70);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule